// File: doc/BRIEF.md
# ADC Initialization and Release Sequencer

This block decides when the capture side of an audio converter leaves power-down and when its samples may be trusted. After the power-down input is released, it first waits for a start condition that depends on the interface role and the serial format. It then counts frame-clock rising edges up to a terminal count. The length of that window depends on the speed class and on whether the converter drives the serial clocks (master) or receives them (slave). While the window runs, both channel outputs are held at two's complement zero. When the count completes, a data-valid flag rises and the channel samples pass through unchanged.

The block runs on one system clock. The bit clock and the frame clock arrive as level inputs that are already synchronous to it, and the block finds their edges itself. The role, format and speed are captured at the moment of release and stay fixed until the next power-down. The window lengths are parameters, and a bench can scale them down.

Top module: `adc_init_seq`

## Requirements
- R1: In slave mode the window is LEN_SLAVE_NORMAL frame-clock rising edges for speed code 2'b00 (normal), 2*LEN_SLAVE_NORMAL-DBL_TRIM for 2'b01 (double) and 4*LEN_SLAVE_NORMAL-QUAD_TRIM for 2'b10 (quad). Code 2'b11 is treated as quad. With the defaults this gives 4134, 8262 and 16518.
- R2: In master mode every window is MASTER_TRIM edges shorter than the slave window (defaults 4131, 8259, 16515). Counting begins the cycle after release, with no wait for any serial-clock edge.
- R3: In slave mode with a format code other than 2'b01 (2'b00 mixed-justified, 2'b10 and 2'b11 left-justified), timing starts on the first frame-clock rising edge after release. That edge is not counted. Bit-clock edges and frame-clock falling edges do not start it.
- R4: In slave mode with format code 2'b01 (I2S), timing starts on a bit-clock falling edge that follows a bit-clock rising edge, which in turn follows a frame-clock falling edge. A frame-clock rising edge seen before that point neither starts nor counts.
- R5: While a slave waits for its start condition, running, init_active and data_valid are all low.
- R6: Whenever data_valid is low, both channel outputs are zero. Once it is high, each output equals its raw input.
- R7: While pwr_down is high, all three flags are low from the first clock edge on. Releasing pwr_down starts a new sequence whose count begins at zero, whatever state came before.
- R8: Changes to the role, format or speed inputs after release have no effect on the start rule or the window length until the next power-down.
- R9: init_active is high from the start condition until the edge that completes the count. data_valid rises on the clock after that edge is seen and stays high until power-down, whatever further frame-clock edges arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| pwr_down | input | 1 | High holds the sequencer in power-down |
| bclk | input | 1 | Serial bit clock level, synchronous to clk |
| lrck | input | 1 | Frame clock level, synchronous to clk |
| fmt_sel | input | 2 | Serial format: 2'b01 I2S, other codes left-justified start |
| spd_sel | input | 2 | Speed class: 00 normal, 01 double, 1x quad |
| master | input | 1 | High when the converter is the clock master |
| adc_l_raw | input | DATA_W | Left channel sample from the converter core |
| adc_r_raw | input | DATA_W | Right channel sample from the converter core |
| adc_l_out | output | DATA_W | Left sample, forced to zero until valid |
| adc_r_out | output | DATA_W | Right sample, forced to zero until valid |
| running | output | 1 | Internal timing has started |
| init_active | output | 1 | Initialization window in progress |
| data_valid | output | 1 | Window complete, samples pass through |

## Verification
Each combination of role, all four speed codes and all four format codes is released from power-down and driven with whole frames. The flags and the zeroed outputs are examined after every frame, which pins each window length to the exact edge and shows whether the start frame was counted. Directed sequences then send lone bit-clock edges, frame-clock falls and early frame-clock rises, which separate the left-justified start rule from the I2S one. A power-down in the middle of a window tells a true restart from a resumed count, and a change of speed, role or format after release tells captured settings from live ones.

// File: rtl/adc_init_pkg.sv
package adc_init_pkg;

  typedef enum logic [2:0] {
    SQ_DOWN       = 3'd0,
    SQ_WAIT_LRISE = 3'd1,
    SQ_WAIT_LFALL = 3'd2,
    SQ_WAIT_BRISE = 3'd3,
    SQ_WAIT_BFALL = 3'd4,
    SQ_INIT       = 3'd5,
    SQ_VALID      = 3'd6
  } seq_state_e;

  // Window length in frame-clock rising edges for a speed class and role.
  function automatic int unsigned init_len(input logic [1:0] spd,
                                           input logic       mstr,
                                           input int unsigned sn,
                                           input int unsigned dtrim,
                                           input int unsigned qtrim,
                                           input int unsigned mtrim);
    int unsigned base;
    case (spd)
      2'b00:   base = sn;
      2'b01:   base = 2 * sn - dtrim;
      default: base = 4 * sn - qtrim;
    endcase
    return mstr ? (base - mtrim) : base;
  endfunction

  function automatic logic fmt_is_i2s(input logic [1:0] fmt);
    return fmt == 2'b01;
  endfunction

endpackage

// File: rtl/adc_init_edges.sv
module adc_init_edges #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);

  logic [N-1:0] sig_q;

  for (genvar i = 0; i < N; i++) begin : g_edge
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sig_q[i] <= 1'b0;
      else        sig_q[i] <= sig[i];
    end
    assign rise[i] = sig[i] & ~sig_q[i];
    assign fall[i] = ~sig[i] & sig_q[i];
  end

endmodule

// File: rtl/adc_init_fsm.sv
module adc_init_fsm
  import adc_init_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_down,
  input  logic       master,
  input  logic [1:0] fmt_sel,
  input  logic       lrck_rise,
  input  logic       lrck_fall,
  input  logic       bclk_rise,
  input  logic       bclk_fall,
  input  logic       cnt_hit,
  output logic       load,
  output logic       cfg_master,
  output logic       cfg_i2s,
  output logic       count_en,
  output logic       running,
  output logic       init_active,
  output logic       data_valid
);

  seq_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    load = 1'b0;
    if (pwr_down) begin
      st_d = SQ_DOWN;
    end else begin
      case (st_q)
        SQ_DOWN: begin
          load = 1'b1;
          if (master)                st_d = SQ_INIT;
          else if (fmt_is_i2s(fmt_sel)) st_d = SQ_WAIT_LFALL;
          else                       st_d = SQ_WAIT_LRISE;
        end
        SQ_WAIT_LRISE: if (lrck_rise) st_d = SQ_INIT;
        SQ_WAIT_LFALL: if (lrck_fall) st_d = SQ_WAIT_BRISE;
        SQ_WAIT_BRISE: if (bclk_rise) st_d = SQ_WAIT_BFALL;
        SQ_WAIT_BFALL: if (bclk_fall) st_d = SQ_INIT;
        SQ_INIT:       if (cnt_hit)   st_d = SQ_VALID;
        SQ_VALID:      st_d = SQ_VALID;
        default:       st_d = SQ_DOWN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= SQ_DOWN;
      cfg_master <= 1'b0;
      cfg_i2s    <= 1'b0;
    end else begin
      st_q <= st_d;
      if (load) begin
        cfg_master <= master;
        cfg_i2s    <= fmt_is_i2s(fmt_sel);
      end
    end
  end

  assign count_en    = (st_q == SQ_INIT);
  assign init_active = (st_q == SQ_INIT);
  assign data_valid  = (st_q == SQ_VALID);
  assign running     = (st_q == SQ_INIT) || (st_q == SQ_VALID);

endmodule

// File: rtl/adc_init_cnt.sv
module adc_init_cnt
  import adc_init_pkg::*;
#(
  parameter int unsigned LEN_SLAVE_NORMAL = 4134,
  parameter int unsigned DBL_TRIM         = 6,
  parameter int unsigned QUAD_TRIM        = 18,
  parameter int unsigned MASTER_TRIM      = 3,
  parameter int          CW               = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_down,
  input  logic          load,
  input  logic [1:0]    spd_sel,
  input  logic          master,
  input  logic          count_en,
  input  logic          lrck_rise,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] term_q,
  output logic          hit
);

  logic [CW-1:0] cnt_next;

  assign cnt_next = cnt_q + CW'(1);
  assign hit      = count_en && lrck_rise && (cnt_next == term_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      term_q <= '0;
    end else if (pwr_down) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q  <= '0;
      term_q <= CW'(init_len(spd_sel, master, LEN_SLAVE_NORMAL,
                             DBL_TRIM, QUAD_TRIM, MASTER_TRIM));
    end else if (count_en && lrck_rise) begin
      cnt_q <= cnt_next;
    end
  end

endmodule

// File: rtl/adc_init_gate.sv
module adc_init_gate #(
  parameter int W  = 24,
  parameter int CH = 2
) (
  input  logic                valid,
  input  logic [CH-1:0][W-1:0] raw,
  output logic [CH-1:0][W-1:0] out
);

  for (genvar c = 0; c < CH; c++) begin : g_ch
    assign out[c] = valid ? raw[c] : '0;
  end

endmodule

// File: rtl/adc_init_seq.sv
module adc_init_seq #(
  parameter int unsigned LEN_SLAVE_NORMAL = 4134,
  parameter int unsigned DBL_TRIM         = 6,
  parameter int unsigned QUAD_TRIM        = 18,
  parameter int unsigned MASTER_TRIM      = 3,
  parameter int          DATA_W           = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_down,
  input  logic              bclk,
  input  logic              lrck,
  input  logic [1:0]        fmt_sel,
  input  logic [1:0]        spd_sel,
  input  logic              master,
  input  logic [DATA_W-1:0] adc_l_raw,
  input  logic [DATA_W-1:0] adc_r_raw,
  output logic [DATA_W-1:0] adc_l_out,
  output logic [DATA_W-1:0] adc_r_out,
  output logic              running,
  output logic              init_active,
  output logic              data_valid
);

  localparam int unsigned MAX_LEN = 4 * LEN_SLAVE_NORMAL;
  localparam int          CW      = $clog2(MAX_LEN + 1);
  localparam int          NCH     = 2;

  logic [1:0] edge_rise, edge_fall;
  logic       lrck_rise, lrck_fall, bclk_rise, bclk_fall;
  logic       load, hit, count_en, cfg_master, cfg_i2s;
  logic [CW-1:0] cnt_q, term_q;
  logic [NCH-1:0][DATA_W-1:0] raw_pk, out_pk;

  adc_init_edges #(.N(2)) u_edges (
    .clk  (clk),
    .rst_n(rst_n),
    .sig  ({bclk, lrck}),
    .rise (edge_rise),
    .fall (edge_fall)
  );

  assign lrck_rise = edge_rise[0];
  assign lrck_fall = edge_fall[0];
  assign bclk_rise = edge_rise[1];
  assign bclk_fall = edge_fall[1];

  adc_init_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_down   (pwr_down),
    .master     (master),
    .fmt_sel    (fmt_sel),
    .lrck_rise  (lrck_rise),
    .lrck_fall  (lrck_fall),
    .bclk_rise  (bclk_rise),
    .bclk_fall  (bclk_fall),
    .cnt_hit    (hit),
    .load       (load),
    .cfg_master (cfg_master),
    .cfg_i2s    (cfg_i2s),
    .count_en   (count_en),
    .running    (running),
    .init_active(init_active),
    .data_valid (data_valid)
  );

  adc_init_cnt #(
    .LEN_SLAVE_NORMAL(LEN_SLAVE_NORMAL),
    .DBL_TRIM        (DBL_TRIM),
    .QUAD_TRIM       (QUAD_TRIM),
    .MASTER_TRIM     (MASTER_TRIM),
    .CW              (CW)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_down (pwr_down),
    .load     (load),
    .spd_sel  (spd_sel),
    .master   (master),
    .count_en (count_en),
    .lrck_rise(lrck_rise),
    .cnt_q    (cnt_q),
    .term_q   (term_q),
    .hit      (hit)
  );

  assign raw_pk[0] = adc_l_raw;
  assign raw_pk[1] = adc_r_raw;

  adc_init_gate #(.W(DATA_W), .CH(NCH)) u_gate (
    .valid(data_valid),
    .raw  (raw_pk),
    .out  (out_pk)
  );

  assign adc_l_out = out_pk[0];
  assign adc_r_out = out_pk[1];

endmodule

// File: rtl/adc_init_seq_chk.sv
module adc_init_seq_chk #(
  parameter int CW = 15,
  parameter int W  = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pwr_down,
  input logic          running,
  input logic          init_active,
  input logic          data_valid,
  input logic [W-1:0]  adc_l_out,
  input logic [W-1:0]  adc_r_out,
  input logic [CW-1:0] cnt_q,
  input logic [CW-1:0] term_q,
  input logic          lrck_rise,
  input logic          bclk_fall,
  input logic          cfg_master,
  input logic          cfg_i2s
);

  AST_PDN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> (!running && !data_valid && cnt_q == '0)); // R7

  AST_ZERO_UNTIL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    init_active |-> (adc_l_out == '0 && adc_r_out == '0)); // R6

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt_q <= term_q)); // R1

  AST_VALID_AT_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_valid) |-> (cnt_q == term_q)); // R9

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && !pwr_down) |=> data_valid); // R9

  AST_TERM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !pwr_down) |=> $stable(term_q)); // R8

  AST_LJ_START_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(init_active) && !cfg_master && !cfg_i2s) |-> $past(lrck_rise)); // R3

  AST_I2S_START_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(init_active) && !cfg_master && cfg_i2s) |-> $past(bclk_fall)); // R4

  AST_COUNT_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (init_active && !lrck_rise && !pwr_down) |=> $stable(cnt_q)); // R1

endmodule

bind adc_init_seq adc_init_seq_chk #(.CW(CW), .W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwr_down   (pwr_down),
  .running    (running),
  .init_active(init_active),
  .data_valid (data_valid),
  .adc_l_out  (adc_l_out),
  .adc_r_out  (adc_r_out),
  .cnt_q      (cnt_q),
  .term_q     (term_q),
  .lrck_rise  (lrck_rise),
  .bclk_fall  (bclk_fall),
  .cfg_master (cfg_master),
  .cfg_i2s    (cfg_i2s)
);

// File: tb/tb_adc_init_seq.sv
module tb_adc_init_seq;

  localparam int SN = 10;
  localparam int DT = 2;
  localparam int QT = 6;
  localparam int MT = 3;
  localparam int W  = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_down = 1'b1;
  logic bclk = 1'b1;
  logic lrck = 1'b1;
  logic [1:0] fmt_sel = 2'b00;
  logic [1:0] spd_sel = 2'b00;
  logic master = 1'b0;
  logic [W-1:0] l_raw = 24'h3A5C01;
  logic [W-1:0] r_raw = 24'hC0FFEE;
  logic [W-1:0] l_out, r_out;
  logic running, init_active, data_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  adc_init_seq #(
    .LEN_SLAVE_NORMAL(SN), .DBL_TRIM(DT), .QUAD_TRIM(QT),
    .MASTER_TRIM(MT), .DATA_W(W)
  ) dut (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .bclk(bclk), .lrck(lrck),
    .fmt_sel(fmt_sel), .spd_sel(spd_sel), .master(master),
    .adc_l_raw(l_raw), .adc_r_raw(r_raw), .adc_l_out(l_out), .adc_r_out(r_out),
    .running(running), .init_active(init_active), .data_valid(data_valid)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic l, input logic b);
    lrck = l;
    bclk = b;
    tick();
  endtask

  // One frame: frame clock falls, two bit periods, rises, two bit periods.
  task automatic frame();
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
  endtask

  function automatic int exp_len(input logic [1:0] s, input logic m);
    int v;
    if (s == 2'b00)      v = SN;
    else if (s == 2'b01) v = (SN - DT / 2) * 2;
    else                 v = SN * 4 - QT;
    if (m) v = v - MT;
    return v;
  endfunction

  task automatic enter_down();
    pwr_down = 1'b1;
    lrck = 1'b1;
    bclk = 1'b1;
    tick();
    tick();
    chk(!running && !init_active && !data_valid, "R7 flags low in power-down",
        {running, init_active, data_valid}, 0);
    chk(l_out == 0 && r_out == 0, "R6 zero in power-down", l_out | r_out, 0);
  endtask

  // Release, then run whole frames and check the flags after each one.
  task automatic run_cfg(input logic m, input logic [1:0] s, input logic [1:0] f);
    int len, pre, counted;
    enter_down();
    master = m; spd_sel = s; fmt_sel = f;
    pwr_down = 1'b0;
    tick();
    chk(running == m, "R2/R5 running right after release", running, m);
    len = exp_len(s, m);
    pre = (!m && f != 2'b01) ? 1 : 0;
    for (int k = 1; k <= len + pre; k++) begin
      frame();
      counted = k - pre;
      if (counted < len) begin
        chk(init_active && !data_valid, m ? "R2 window open" : "R1 window open",
            {init_active, data_valid}, 2'b10);
        chk(l_out == 0 && r_out == 0, "R6 zero while initializing", l_out | r_out, 0);
      end else begin
        chk(!init_active && data_valid, m ? "R2 valid at count" : "R1 valid at count",
            {init_active, data_valid}, 2'b01);
        chk(l_out == l_raw && r_out == r_raw, "R6 pass-through when valid", l_out, l_raw);
      end
    end
    frame();
    frame();
    chk(data_valid && !init_active, "R9 valid holds after extra edges", data_valid, 1);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick();
    tick();
    chk(!running && !init_active && !data_valid, "R7 reset state",
        {running, init_active, data_valid}, 0);
    rst_n = 1'b1;
    tick();

    // Sweep over role, speed code and format code.
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 4; s++)
        for (int f = 0; f < 4; f++)
          run_cfg(m[0], s[1:0], f[1:0]);

    // R3: left-justified slave ignores bit-clock edges and frame-clock falls.
    enter_down();
    master = 1'b0; spd_sel = 2'b00; fmt_sel = 2'b10;
    pwr_down = 1'b0;
    tick();
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    chk(!running && !init_active, "R3 no start before frame rise", running, 0);
    step(1'b1, 1'b0);
    chk(init_active && !data_valid, "R3 start on frame rise", init_active, 1);
    for (int k = 1; k < SN; k++) frame();
    chk(!data_valid, "R3 start edge not counted", data_valid, 0);
    frame();
    chk(data_valid, "R3 valid after count", data_valid, 1);

    // R4: I2S slave start sequence.
    enter_down();
    master = 1'b0; spd_sel = 2'b00; fmt_sel = 2'b01;
    pwr_down = 1'b0;
    tick();
    step(1'b1, 1'b0);
    chk(!running, "R4 lone bit fall ignored", running, 0);
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    chk(!running, "R4 frame rise before bit edges ignored", running, 0);
    step(1'b1, 1'b1);
    chk(!running && !init_active, "R5 still waiting after bit rise", running, 0);
    step(1'b1, 1'b0);
    chk(init_active, "R4 start on bit fall", init_active, 1);
    for (int k = 1; k < SN; k++) frame();
    chk(!data_valid, "R4 early frame rise not counted", data_valid, 0);
    frame();
    chk(data_valid, "R4 valid after count", data_valid, 1);

    // R7: power-down mid-window restarts from zero.
    enter_down();
    master = 1'b1; spd_sel = 2'b00; fmt_sel = 2'b00;
    pwr_down = 1'b0;
    tick();
    for (int k = 0; k < 4; k++) frame();
    pwr_down = 1'b1;
    tick();
    chk(!running && !init_active && !data_valid, "R7 abort clears flags",
        {running, init_active, data_valid}, 0);
    pwr_down = 1'b0;
    tick();
    for (int k = 1; k < SN - MT; k++) frame();
    chk(init_active && !data_valid, "R7 count restarted", data_valid, 0);
    frame();
    chk(data_valid, "R7 valid after full new window", data_valid, 1);

    // R8: settings changed after release are ignored.
    enter_down();
    master = 1'b1; spd_sel = 2'b00; fmt_sel = 2'b00;
    pwr_down = 1'b0;
    tick();
    frame();
    frame();
    spd_sel = 2'b10; master = 1'b0; fmt_sel = 2'b01;
    for (int k = 3; k < SN - MT; k++) frame();
    chk(!data_valid && init_active, "R8 window unchanged before end", data_valid, 0);
    frame();
    chk(data_valid, "R8 captured length used", data_valid, 1);

    enter_down();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule